// File: doc/BRIEF.md
# Branch Record Ring Buffer

This block keeps a circular history of control-transfer records. Each record is three words: a source word (source PC plus a valid flag), a target word (target PC plus a mispredict flag) and a data word that carries cycle-count fields and a transfer type. A capture strobe appends one record at the slot named by the write pointer and then moves the pointer on. Capture stops while the buffer is frozen.

Software sees six registers, picked by a 3-bit register code: a depth register, a status register (frozen flag and write pointer), a select register, and three alias ports that reach the source, target and data words of the selected entry. Entries are numbered newest-first. Logical entry 0 is always the most recent record, whatever the physical position of the pointer. The usable depth is any power of two from 16 to 256 that the `SUPPORTED` parameter enables, and software can change it at run time. Storage is sized for the largest enabled depth.

Top module: `brr_ring`

## Requirements
- R1: After reset the depth code is the smallest code enabled in `SUPPORTED` (0 by default), the write pointer and the frozen flag are 0, and the valid flag of every slot reads 0.
- R2: The depth register (code 0) holds a 3-bit depth code in bits 2:0, and the entry count is 2^(code+4). A write takes effect only if the code is at most 4 and its bit in `SUPPORTED` is set. Any other write leaves the code unchanged. Reads return the code zero-extended.
- R3: When a depth write is accepted, the stored write pointer is ANDed with the mask of the new depth. The masks are 0x0F, 0x1F, 0x3F, 0x7F and 0xFF for codes 0 to 4.
- R4: The status register (code 1) reads as the frozen flag at bit 31, the 8-bit write pointer at bits 7:0, and zero in all other bits. A write stores bit 31 into the frozen flag and stores bits 7:0 ANDed with the current mask into the pointer.
- R5: An accepted capture writes the record into the slot at the write pointer. The pointer then becomes (pointer + 1) AND mask, so it wraps at the current depth.
- R6: While the frozen flag is set, a capture strobe changes neither the pointer nor any slot.
- R7: The select register is code 2. The alias ports for source, target and data words are codes 3, 4 and 5. The selected logical entry N = select[7:0] reaches physical slot ((pointer − N − 1) AND mask), so entry 0 is the newest record.
- R8: A select is valid only while `feat_en` is high and select[7:0] is below the largest enabled entry count. With an invalid select, alias reads return zero and alias writes change nothing.
- R9: In a cycle where software writes any register, a capture strobe is discarded: no slot is written and the pointer takes only the software result.
- R10: A captured source word reads back as {source PC, 1}. A captured target word reads back as {target PC, mispredict}. The data word (exponent 31:28, mantissa 27:16, count-valid 15, type 3:0) reads back unchanged. Alias writes store the full written word, including bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Feature enable; gates alias access |
| sw_we | input | 1 | Software register write strobe |
| sw_addr | input | 3 | Register code (0 depth, 1 status, 2 select, 3 source, 4 target, 5 data) |
| sw_wdata | input | XLEN | Software write data |
| sw_rdata | output | XLEN | Combinational read data for `sw_addr` |
| cap_i | input | 1 | Record capture strobe |
| cap_src_pc | input | XLEN-1 | Source PC of the record (word bits XLEN-1:1) |
| cap_tgt_pc | input | XLEN-1 | Target PC of the record (word bits XLEN-1:1) |
| cap_mispred | input | 1 | Mispredict flag for the target word |
| cap_data | input | DATA_W | Record data word |

## Verification
Directed cases come first. They cover the depth codes that must be refused (unsupported 3 and 4, out-of-range 5 and 7), a shrink of the depth with a large pointer so the re-mask is visible, and an all-ones status write. They also cover captures while frozen, a run of captures that wraps the 16-entry ring, and a capture that collides with a software write. After these, a seeded random mix of captures, depth, status and select writes, alias writes and enable toggles runs against a bench model. Every alias read is compared with the model. This tells a newest-first mapping apart from an oldest-first or off-by-one one, a pointer masked by the current depth apart from one masked by the largest depth, and a select gate that uses the largest count apart from one that uses the current depth.

// File: rtl/brr_pkg.sv
package brr_pkg;

    localparam int CODE_W   = 3;
    localparam int MAX_CODE = 4;
    localparam int PTR_W    = 8;
    localparam int MIN_LOG  = 4;

    typedef enum logic [2:0] {
        REG_DEPTH  = 3'd0,
        REG_STATUS = 3'd1,
        REG_SELECT = 3'd2,
        REG_SRC    = 3'd3,
        REG_TGT    = 3'd4,
        REG_DATA   = 3'd5
    } reg_addr_e;

    // pointer mask for a depth code: 2^(code+4) - 1
    function automatic logic [PTR_W-1:0] ptr_mask(input logic [CODE_W-1:0] code);
        logic [PTR_W:0] span;
        span = (PTR_W+1)'(1) << (int'(code) + MIN_LOG);
        return PTR_W'(span - (PTR_W+1)'(1));
    endfunction

    // depth code is in range and enabled in the support vector
    function automatic logic code_ok(input logic [MAX_CODE:0] sup,
                                     input logic [CODE_W-1:0] code);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i <= MAX_CODE; i++) begin
            if (sup[i] && (code == CODE_W'(i))) ok = 1'b1;
        end
        return ok;
    endfunction

    function automatic int top_code(input logic [MAX_CODE:0] sup);
        int t;
        t = 0;
        for (int i = 0; i <= MAX_CODE; i++) begin
            if (sup[i]) t = i;
        end
        return t;
    endfunction

    function automatic int low_code(input logic [MAX_CODE:0] sup);
        int t;
        t = 0;
        for (int i = MAX_CODE; i >= 0; i--) begin
            if (sup[i]) t = i;
        end
        return t;
    endfunction

endpackage

// File: rtl/brr_cfg.sv
module brr_cfg
    import brr_pkg::*;
#(
    parameter int                 XLEN      = 32,
    parameter logic [MAX_CODE:0]  SUPPORTED = 5'b00111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_we,
    input  logic [2:0]          sw_addr,
    input  logic [XLEN-1:0]     sw_wdata,
    input  logic                cap_i,
    output logic                cap_acc,
    output logic [CODE_W-1:0]   depth,
    output logic [PTR_W-1:0]    wrptr,
    output logic                frozen,
    output logic [XLEN-1:0]     sel
);

    localparam int RST_CODE = low_code(SUPPORTED);

    typedef struct packed {
        logic [CODE_W-1:0] depth;
        logic              frozen;
        logic [PTR_W-1:0]  wrptr;
        logic [XLEN-1:0]   sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [PTR_W-1:0] mask_cur;

    assign mask_cur = ptr_mask(cfg_q.depth);
    assign cap_acc  = cap_i && !cfg_q.frozen && !sw_we;

    always_comb begin
        cfg_d = cfg_q;
        if (sw_we) begin
            case (sw_addr)
                REG_DEPTH: begin
                    if (code_ok(SUPPORTED, sw_wdata[CODE_W-1:0])) begin
                        cfg_d.depth = sw_wdata[CODE_W-1:0];
                        cfg_d.wrptr = cfg_q.wrptr & ptr_mask(sw_wdata[CODE_W-1:0]);
                    end
                end
                REG_STATUS: begin
                    cfg_d.frozen = sw_wdata[31];
                    cfg_d.wrptr  = sw_wdata[PTR_W-1:0] & mask_cur;
                end
                REG_SELECT: cfg_d.sel = sw_wdata;
                default: ;
            endcase
        end else if (cap_acc) begin
            cfg_d.wrptr = (cfg_q.wrptr + PTR_W'(1)) & mask_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.depth  <= CODE_W'(RST_CODE);
            cfg_q.frozen <= 1'b0;
            cfg_q.wrptr  <= '0;
            cfg_q.sel    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign depth  = cfg_q.depth;
    assign wrptr  = cfg_q.wrptr;
    assign frozen = cfg_q.frozen;
    assign sel    = cfg_q.sel;

    // R2
    depth_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(SUPPORTED, cfg_q.depth));

    // R3
    wrptr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.wrptr & ~ptr_mask(cfg_q.depth)) == '0);

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.frozen && cap_i && !sw_we) |=> (cfg_q.wrptr == $past(cfg_q.wrptr)));

    // R5
    cap_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !cfg_q.frozen && !sw_we) |=>
        (cfg_q.wrptr == (($past(cfg_q.wrptr) + PTR_W'(1)) & ptr_mask(cfg_q.depth))));

endmodule

// File: rtl/brr_map.sv
module brr_map
    import brr_pkg::*;
#(
    parameter int NSLOT  = 64,
    parameter int SLOT_W = 6
) (
    input  logic [SLOT_W-1:0] wrptr_lo,
    input  logic [PTR_W-1:0]  sel_lo,
    input  logic [CODE_W-1:0] depth,
    input  logic              feat_en,
    output logic [SLOT_W-1:0] slot,
    output logic              sel_ok
);

    logic [SLOT_W-1:0] back;

    always_comb begin
        back   = wrptr_lo - sel_lo[SLOT_W-1:0] - SLOT_W'(1);
        slot   = back & SLOT_W'(ptr_mask(depth));
        sel_ok = feat_en && ({1'b0, sel_lo} < (PTR_W+1)'(NSLOT));
    end

endmodule

// File: rtl/brr_store.sv
module brr_store #(
    parameter int XLEN   = 32,
    parameter int DATA_W = 32,
    parameter int NSLOT  = 64,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_we,
    input  logic [SLOT_W-1:0] cap_slot,
    input  logic [XLEN-2:0]   cap_src_pc,
    input  logic [XLEN-2:0]   cap_tgt_pc,
    input  logic              cap_mispred,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              sw_src_we,
    input  logic              sw_tgt_we,
    input  logic              sw_dat_we,
    input  logic [SLOT_W-1:0] sw_slot,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   rd_src,
    output logic [XLEN-1:0]   rd_tgt,
    output logic [DATA_W-1:0] rd_dat
);

    typedef struct packed {
        logic              src_we;
        logic              tgt_we;
        logic              dat_we;
        logic [SLOT_W-1:0] slot;
        logic [XLEN-2:0]   pc;
        logic              vld;
        logic [XLEN-1:0]   tgt;
        logic [DATA_W-1:0] dat;
    } wr_t;

    wr_t              wr_d;
    logic [NSLOT-1:0] valid_d, valid_q;
    logic [XLEN-2:0]   src_mem [NSLOT];
    logic [XLEN-1:0]   tgt_mem [NSLOT];
    logic [DATA_W-1:0] dat_mem [NSLOT];

    always_comb begin
        wr_d = '0;
        if (cap_we) begin
            wr_d.src_we = 1'b1;
            wr_d.tgt_we = 1'b1;
            wr_d.dat_we = 1'b1;
            wr_d.slot   = cap_slot;
            wr_d.pc     = cap_src_pc;
            wr_d.vld    = 1'b1;
            wr_d.tgt    = {cap_tgt_pc, cap_mispred};
            wr_d.dat    = cap_data;
        end else begin
            wr_d.src_we = sw_src_we;
            wr_d.tgt_we = sw_tgt_we;
            wr_d.dat_we = sw_dat_we;
            wr_d.slot   = sw_slot;
            wr_d.pc     = sw_wdata[XLEN-1:1];
            wr_d.vld    = sw_wdata[0];
            wr_d.tgt    = sw_wdata;
            wr_d.dat    = sw_wdata[DATA_W-1:0];
        end
        valid_d = valid_q;
        if (wr_d.src_we) valid_d[wr_d.slot] = wr_d.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_d.src_we) src_mem[wr_d.slot] <= wr_d.pc;
        if (wr_d.tgt_we) tgt_mem[wr_d.slot] <= wr_d.tgt;
        if (wr_d.dat_we) dat_mem[wr_d.slot] <= wr_d.dat;
    end

    assign rd_src = {src_mem[sw_slot], valid_q[sw_slot]};
    assign rd_tgt = tgt_mem[sw_slot];
    assign rd_dat = dat_mem[sw_slot];

    // R5
    cap_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |=> valid_q[$past(cap_slot)]);

endmodule

// File: rtl/brr_ring.sv
module brr_ring
    import brr_pkg::*;
#(
    parameter int                XLEN      = 32,
    parameter int                DATA_W    = 32,
    parameter logic [MAX_CODE:0] SUPPORTED = 5'b00111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en,
    input  logic              sw_we,
    input  logic [2:0]        sw_addr,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   sw_rdata,
    input  logic              cap_i,
    input  logic [XLEN-2:0]   cap_src_pc,
    input  logic [XLEN-2:0]   cap_tgt_pc,
    input  logic              cap_mispred,
    input  logic [DATA_W-1:0] cap_data
);

    localparam int TOP_CODE = top_code(SUPPORTED);
    localparam int SLOT_W   = TOP_CODE + MIN_LOG;
    localparam int NSLOT    = 1 << SLOT_W;

    logic              cap_acc;
    logic [CODE_W-1:0] depth;
    logic [PTR_W-1:0]  wrptr;
    logic              frozen;
    logic [XLEN-1:0]   sel;
    logic [SLOT_W-1:0] slot;
    logic              sel_ok;
    logic              src_we, tgt_we, dat_we;
    logic [XLEN-1:0]   rd_src, rd_tgt;
    logic [DATA_W-1:0] rd_dat;

    brr_cfg #(.XLEN(XLEN), .SUPPORTED(SUPPORTED)) i_cfg (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .cap_i(cap_i), .cap_acc(cap_acc),
        .depth(depth), .wrptr(wrptr), .frozen(frozen), .sel(sel)
    );

    brr_map #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) i_map (
        .wrptr_lo(wrptr[SLOT_W-1:0]), .sel_lo(sel[PTR_W-1:0]),
        .depth(depth), .feat_en(feat_en), .slot(slot), .sel_ok(sel_ok)
    );

    assign src_we = sw_we && sel_ok && (sw_addr == REG_SRC);
    assign tgt_we = sw_we && sel_ok && (sw_addr == REG_TGT);
    assign dat_we = sw_we && sel_ok && (sw_addr == REG_DATA);

    brr_store #(.XLEN(XLEN), .DATA_W(DATA_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .cap_we(cap_acc), .cap_slot(wrptr[SLOT_W-1:0]),
        .cap_src_pc(cap_src_pc), .cap_tgt_pc(cap_tgt_pc),
        .cap_mispred(cap_mispred), .cap_data(cap_data),
        .sw_src_we(src_we), .sw_tgt_we(tgt_we), .sw_dat_we(dat_we),
        .sw_slot(slot), .sw_wdata(sw_wdata),
        .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_dat(rd_dat)
    );

    always_comb begin
        sw_rdata = '0;
        case (sw_addr)
            REG_DEPTH:  sw_rdata = XLEN'(depth);
            REG_STATUS: sw_rdata = XLEN'({frozen, 23'd0, wrptr});
            REG_SELECT: sw_rdata = sel;
            REG_SRC:    if (sel_ok) sw_rdata = rd_src;
            REG_TGT:    if (sel_ok) sw_rdata = rd_tgt;
            REG_DATA:   if (sel_ok) sw_rdata = XLEN'(rd_dat);
            default:    sw_rdata = '0;
        endcase
    end

    // R8
    alias_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && (sw_addr >= 3'd3) && (sw_addr <= 3'd5)) |-> (sw_rdata == '0));

    // R9
    sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && cap_i && (sw_addr != REG_DEPTH) && (sw_addr != REG_STATUS))
        |=> (wrptr == $past(wrptr)));

endmodule

// File: tb/test_brr_ring.sv
`timescale 1ns/1ps
module test_brr_ring;

    localparam logic [4:0] SUP = 5'b00111;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b0;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        cap_i = 1'b0;
    logic [30:0] cap_src_pc = '0;
    logic [30:0] cap_tgt_pc = '0;
    logic        cap_mispred = 1'b0;
    logic [31:0] cap_data = '0;

    always #5 clk = ~clk;

    brr_ring i_brr_ring (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .cap_i(cap_i), .cap_src_pc(cap_src_pc), .cap_tgt_pc(cap_tgt_pc),
        .cap_mispred(cap_mispred), .cap_data(cap_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int unsigned m_depth, m_wrptr;
    bit          m_frozen;
    logic [31:0] m_sel;
    logic [31:0] m_src [NS];
    logic [31:0] m_tgt [NS];
    logic [31:0] m_dat [NS];

    function automatic int unsigned fmask(int unsigned c);
        return (16 << c) - 1;
    endfunction

    function automatic bit fsup(int unsigned c);
        return (c <= 4) && SUP[c];
    endfunction

    function automatic bit fselok();
        return feat_en && (m_sel[7:0] < NS);
    endfunction

    function automatic int unsigned fphys();
        return (m_wrptr - m_sel[7:0] - 1) & fmask(m_depth);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        sw_addr = 3'(a);
        #1;
        v = sw_rdata;
    endtask

    // one clock: optional software write and optional capture, model updated
    task automatic cyc(input bit we, input int a, input logic [31:0] wd,
                       input bit cp, input logic [30:0] sp, input logic [30:0] tp,
                       input bit mp, input logic [31:0] dt);
        int unsigned p;
        @(negedge clk);
        sw_we = we; sw_addr = 3'(a); sw_wdata = wd;
        cap_i = cp; cap_src_pc = sp; cap_tgt_pc = tp; cap_mispred = mp; cap_data = dt;
        p = fphys();
        if (we) begin
            case (a)
                0: if (fsup(wd[2:0])) begin m_depth = wd[2:0]; m_wrptr &= fmask(m_depth); end
                1: begin m_frozen = wd[31]; m_wrptr = wd[7:0] & fmask(m_depth); end
                2: m_sel = wd;
                3: if (fselok()) m_src[p] = wd;
                4: if (fselok()) m_tgt[p] = wd;
                5: if (fselok()) m_dat[p] = wd;
                default: ;
            endcase
        end else if (cp && !m_frozen) begin
            m_src[m_wrptr] = {sp, 1'b1};
            m_tgt[m_wrptr] = {tp, mp};
            m_dat[m_wrptr] = dt;
            m_wrptr = (m_wrptr + 1) & fmask(m_depth);
        end
        @(posedge clk);
        #1;
        sw_we = 1'b0; cap_i = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] wd);
        cyc(1'b1, a, wd, 1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic cap(input logic [30:0] sp, input logic [30:0] tp, input bit mp, input logic [31:0] dt);
        cyc(1'b0, 0, '0, 1'b1, sp, tp, mp, dt);
    endtask

    task automatic chk_regs(input string tag);
        logic [31:0] v;
        rd(0, v); chk(v, 32'(m_depth), {tag, " R2 depth"});
        rd(1, v); chk(v, {m_frozen, 23'd0, 8'(m_wrptr)}, {tag, " R4 status"});
    endtask

    task automatic chk_entry(input string tag);
        logic [31:0] v;
        int unsigned p;
        p = fphys();
        rd(3, v); chk(v, fselok() ? m_src[p] : 32'h0, {tag, " R7 src"});
        rd(4, v); chk(v, fselok() ? m_tgt[p] : 32'h0, {tag, " R7 tgt"});
        rd(5, v); chk(v, fselok() ? m_dat[p] : 32'h0, {tag, " R7 data"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED));
        m_depth = 0; m_wrptr = 0; m_frozen = 0; m_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk_regs("R1 reset");
        feat_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            wr(2, 32'(i));
            rd(3, v); chk(v & 32'h1, 32'h0, "R1 valid cleared");
        end

        // fill every slot at depth code 2 (64 entries)
        wr(0, 32'd2); chk_regs("R2 accept");
        for (int i = 0; i < NS; i++) begin
            wr(2, 32'(i));
            wr(3, $urandom()); wr(4, $urandom()); wr(5, $urandom());
            chk_entry("R10 alias write");
        end

        // R2 refused codes
        wr(0, 32'd3); chk_regs("R2 unsupported 3");
        wr(0, 32'd4); chk_regs("R2 unsupported 4");
        wr(0, 32'd5); chk_regs("R2 range 5");
        wr(0, 32'hFFFF_FFF7); chk_regs("R2 range 7");

        // R3 re-mask on shrink
        wr(1, 32'h0000_003A); chk_regs("R4 ptr");
        wr(0, 32'd0); chk_regs("R3 shrink");
        rd(1, v); chk(v, 32'h0000_000A, "R3 remask value");

        // R4 all ones
        wr(1, 32'hFFFF_FFFF);
        rd(1, v); chk(v, 32'h8000_000F, "R4 all ones");

        // R6 frozen capture
        wr(2, 32'd0);
        for (int i = 0; i < 3; i++) begin
            cap(31'(i + 100), 31'(i + 200), 1'b1, 32'hA5A5_0000);
            chk_regs("R6 frozen"); chk_entry("R6 frozen");
        end

        // R5 wrap at 16, R7 newest first, R10 layout
        wr(1, 32'h0000_000C);
        for (int i = 0; i < 20; i++) begin
            cap(31'(32'h1000 + i), 31'(32'h2000 + i), i[0], {4'(i), 12'(i * 3), 1'b1, 11'd0, 4'(i)});
            chk_regs("R5 capture");
        end
        rd(1, v); chk(v, 32'h0000_0000, "R5 wrap");
        for (int n = 0; n < 4; n++) begin
            wr(2, 32'(n));
            rd(3, v); chk(v, {31'(32'h1000 + 19 - n), 1'b1}, "R7 newest first");
            rd(4, v); chk(v, {31'(32'h2000 + 19 - n), 1'(19 - n)}, "R10 target word");
            chk_entry("R10 entry");
        end

        // R9 software write wins over capture
        cyc(1'b1, 2, 32'd1, 1'b1, 31'h7777, 31'h6666, 1'b0, 32'h1);
        chk_regs("R9 select+cap"); chk_entry("R9 select+cap");
        cyc(1'b1, 1, 32'h0000_0005, 1'b1, 31'h7777, 31'h6666, 1'b0, 32'h1);
        chk_regs("R9 status+cap"); chk_entry("R9 status+cap");

        // R8 invalid selects
        wr(2, 32'd64); chk_entry("R8 sel 64");
        wr(3, 32'hDEAD_BEEF);
        wr(2, 32'h0000_01C8); chk_entry("R8 sel 200");
        wr(2, 32'd2);
        feat_en = 1'b0; #1;
        chk_entry("R8 feature off");
        wr(4, 32'h1234_5678);
        feat_en = 1'b1; #1;
        chk_entry("R8 write discarded");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int unsigned op;
            op = $urandom_range(0, 99);
            if (op < 40)
                cap($urandom(), $urandom(), 1'($urandom()), $urandom());
            else if (op < 48)
                wr(0, 32'($urandom_range(0, 7)));
            else if (op < 54)
                wr(1, ($urandom_range(0, 9) == 0) ? 32'h8000_0000 | $urandom() : $urandom() & 32'h7FFF_FFFF);
            else if (op < 70)
                wr(2, ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 80)));
            else if (op < 80)
                wr($urandom_range(3, 5), $urandom());
            else if (op < 84) begin
                feat_en = ($urandom_range(0, 3) != 0); #1;
            end else
                cyc(1'b1, $urandom_range(0, 5), $urandom(), 1'b1, $urandom(), $urandom(), 1'b0, $urandom());
            chk_regs("R5 random");
            chk_entry("R7 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule